// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer of 64 words, each 36 bits wide. A producer writes it from one clock and a consumer reads it from a second, unrelated clock. On the read side, a request moves the oldest word into an output register. The read data port shows the value of that register.

Four status flags come out of two small state machines, one in each clock domain. The read-side machine drives the data-available flag and the above-low-mark flag. It has three states: `RS_DRY` (nothing stored), `RS_LOW` (1 to X words) and `RS_AMPLE` (more than X words). The write-side machine drives the room flag and the below-high-mark flag. It also has three states: `WS_ROOMY` (fewer than 64−X words), `WS_NEAR` (64−X to 63 words) and `WS_PACKED` (64 words).

On every edge, each machine moves to the state that matches its fill count. The count uses the local pointer, including any transfer on that edge, and the far pointer as captured on the previous edge. So a local write or read changes the flags on the same edge. A change made by the far domain reaches the flags on the second local edge. X is a 6-bit offset taken from `cfg_ofs` on the clock edges where reset is held low. Integrations normally strap it to 8.

Top module: `dcfifo64`

## Requirements
- R1: A write while `wr_room` is 0 stores nothing. A read request while `rd_avail` is 0 leaves `rd_data` unchanged and removes nothing.
- R2: After a write into an empty FIFO, `rd_avail` stays 0 after the first rising `rclk` edge that follows the write edge. It reads 1 after the second.
- R3: An accepted read loads the oldest stored word into the output register, so words come out in write order. Between accepted reads, `rd_data` holds its value.
- R4: After a read frees a location of a full FIFO, `wr_room` stays 0 after the first rising `wclk` edge that follows the read edge. It reads 1 after the second.
- R5: `wr_room` drops to 0 on the write edge that makes the count 64. `rd_avail` drops to 0 on the read edge that takes the last word.
- R6: `wr_below_high` is 0 while the write side sees 64−X or more words, and 1 otherwise.
- R7: `rd_above_low` is 0 while the read side sees 0 to X words, and 1 otherwise.
- R8: X is loaded from `cfg_ofs` on clock edges while `rst_n` is 0. Changes to `cfg_ofs` after reset have no effect on the thresholds.
- R9: After reset, `rd_avail` = 0, `rd_above_low` = 0, `wr_room` = 1 and `wr_below_high` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| cfg_ofs | input | 6 | Offset X for both mark flags, captured during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data |
| wr_room | output | 1 | 1 while at least one location is free |
| wr_below_high | output | 1 | 0 while the count is at or above 64−X |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Output register |
| rd_avail | output | 1 | 1 while a word can be read |
| rd_above_low | output | 1 | 0 while the count is X or fewer |

## Verification
The bench builds the block with its default sizes: 36-bit words, 64 entries and a 6-bit offset. With these sizes a full fill, the overflow attempt and the complete drain take only a few hundred cycles.

Reset is applied once with X = 8 and once with X = 3. This shows that both mark thresholds move with the captured offset, and that a later change on `cfg_ofs` is ignored. The two clocks run at different periods, with rising edges that never coincide. This makes the two-edge crossing latency exact in both directions.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
    // Read-side fill states; bit0 = data available, bit1 = above the low mark
    typedef enum logic [1:0] {
        RS_DRY   = 2'b00,
        RS_LOW   = 2'b01,
        RS_AMPLE = 2'b11
    } rd_state_e;

    // Write-side fill states; bit0 = room left, bit1 = below the high mark
    typedef enum logic [1:0] {
        WS_PACKED = 2'b00,
        WS_NEAR   = 2'b01,
        WS_ROOMY  = 2'b11
    } wr_state_e;
endpackage

// File: rtl/xdom_ptr.sv
`timescale 1ns/1ps
// Captures a Gray-coded pointer from the far domain and returns it in binary.
module xdom_ptr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= gray_in;
    end

    always_comb begin
        bin_out[W-1] = cap_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ cap_q[i];
        end
    end
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [OW-1:0] cfg_ofs,
    input  logic [AW:0]   wbin_s,
    output logic [AW-1:0] raddr,
    output logic          rd_fire,
    output logic [AW:0]   rgray,
    output logic          avail,
    output logic          above_low
);
    localparam int PW = AW + 1;

    rd_state_e      st_q, st_d;
    logic [PW-1:0]  rbin_q, rbin_nxt, fill;
    logic [OW-1:0]  ofs_q;

    assign rd_fire  = rd_en && avail;
    assign rbin_nxt = rbin_q + PW'(rd_fire);
    assign fill     = wbin_s - rbin_nxt;
    assign raddr    = rbin_q[AW-1:0];

    // Offset register: loaded only while reset is held
    always_ff @(posedge rclk) begin
        if (!rst_n) ofs_q <= cfg_ofs;
    end

    always_comb begin
        if (fill == '0)                 st_d = RS_DRY;
        else if (fill <= PW'(ofs_q))    st_d = RS_LOW;
        else                            st_d = RS_AMPLE;
    end

    // State and pointer register
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            st_q   <= RS_DRY;
            rbin_q <= '0;
            rgray  <= '0;
        end else begin
            st_q   <= st_d;
            rbin_q <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            RS_DRY:   begin avail = 1'b0; above_low = 1'b0; end
            RS_LOW:   begin avail = 1'b1; above_low = 1'b0; end
            RS_AMPLE: begin avail = 1'b1; above_low = 1'b1; end
            default:  begin avail = 1'b0; above_low = 1'b0; end
        endcase
    end

    // R1
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !avail) |=> $stable(rbin_q));

    // R5
    avail_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $fell(avail) |-> $past(rd_en));
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side
    import fifo_pkg::*;
#(
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [OW-1:0] cfg_ofs,
    input  logic [AW:0]   rbin_s,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic [AW:0]   wgray,
    output logic          room,
    output logic          below_high
);
    localparam int            PW    = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    wr_state_e      st_q, st_d;
    logic [PW-1:0]  wbin_q, wbin_nxt, fill, high_mark;
    logic [OW-1:0]  ofs_q;

    assign wr_fire   = wr_en && room;
    assign wbin_nxt  = wbin_q + PW'(wr_fire);
    assign fill      = wbin_nxt - rbin_s;
    assign waddr     = wbin_q[AW-1:0];
    assign high_mark = DEPTH - PW'(ofs_q);

    always_ff @(posedge wclk) begin
        if (!rst_n) ofs_q <= cfg_ofs;
    end

    always_comb begin
        if (fill == DEPTH)            st_d = WS_PACKED;
        else if (fill >= high_mark)   st_d = WS_NEAR;
        else                          st_d = WS_ROOMY;
    end

    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            st_q   <= WS_ROOMY;
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            st_q   <= st_d;
            wbin_q <= wbin_nxt;
            wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (st_q)
            WS_ROOMY:  begin room = 1'b1; below_high = 1'b1; end
            WS_NEAR:   begin room = 1'b1; below_high = 1'b0; end
            WS_PACKED: begin room = 1'b0; below_high = 1'b0; end
            default:   begin room = 1'b0; below_high = 1'b0; end
        endcase
    end

    // R1
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !room) |=> $stable(wbin_q));

    // R5
    room_drop_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(room) |-> $past(wr_en));
endmodule

// File: rtl/dcfifo64.sv
`timescale 1ns/1ps
module dcfifo64 #(
    parameter int DW = 36,
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [OW-1:0] cfg_ofs,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_room,
    output logic          wr_below_high,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_avail,
    output logic          rd_above_low
);
    localparam int PW = AW + 1;

    logic [AW-1:0] waddr, raddr;
    logic          wr_fire, rd_fire;
    logic [PW-1:0] wgray, rgray, wbin_s, rbin_s;
    logic [DW-1:0] mem_q;

    fifo_store #(.DW(DW), .AW(AW)) u_store (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    xdom_ptr #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    xdom_ptr #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    fifo_wr_side #(.AW(AW), .OW(OW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_ofs(cfg_ofs),
        .rbin_s(rbin_s), .waddr(waddr), .wr_fire(wr_fire), .wgray(wgray),
        .room(wr_room), .below_high(wr_below_high)
    );

    fifo_rd_side #(.AW(AW), .OW(OW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .cfg_ofs(cfg_ofs),
        .wbin_s(wbin_s), .raddr(raddr), .rd_fire(rd_fire), .rgray(rgray),
        .avail(rd_avail), .above_low(rd_above_low)
    );

    // Output register
    always_ff @(posedge rclk) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_fire) rd_data <= mem_q;
    end

    // R3
    out_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/dcfifo64_test.sv
`timescale 1ns/1ps
module dcfifo64_test;
    logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [5:0]  cfg_ofs = 6'd8;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        wr_room, wr_below_high, rd_avail, rd_above_low;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    // 100 MHz write clock (rises at odd ns); read clock rises at even ns
    always #5 wclk = ~wclk;
    initial begin
        #2 rclk = 1'b1;
        forever #7 rclk = ~rclk;
    end

    dcfifo64 uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_ofs(cfg_ofs),
        .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room),
        .wr_below_high(wr_below_high), .rd_en(rd_en), .rd_data(rd_data),
        .rd_avail(rd_avail), .rd_above_low(rd_above_low)
    );

    function automatic logic [35:0] word(int k);
        return 36'h5_A5A5_0000 ^ 36'(k * 257);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [5:0] ofs);
        rst_n = 1'b0; cfg_ofs = ofs; wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #2 rst_n = 1'b1;
    endtask

    task automatic wwait(int n); repeat (n) @(posedge wclk); #2; endtask
    task automatic rwait(int n); repeat (n) @(posedge rclk); #2; endtask

    task automatic t_reset_state();
        check("R9 rd_avail", rd_avail, 0);
        check("R9 rd_above_low", rd_above_low, 0);
        check("R9 wr_room", wr_room, 1);
        check("R9 wr_below_high", wr_below_high, 1);
    endtask

    task automatic t_empty_latency();
        wwait(1);
        wr_en = 1'b1; wr_data = word(0);
        @(posedge wclk); wr_en <= 1'b0;
        @(posedge rclk); #2 check("R2 first edge", rd_avail, 0);
        @(posedge rclk); #2 check("R2 second edge", rd_avail, 1);
        rd_en = 1'b1; rwait(1); rd_en = 1'b0;
        check("R3 data", rd_data, word(0));
        check("R5 avail drop", rd_avail, 0);
        rd_en = 1'b1; rwait(1); rd_en = 1'b0; rwait(1);
        check("R1 empty read", rd_data, word(0));
    endtask

    task automatic t_fill_and_release();
        wwait(1);
        for (int k = 1; k <= 65; k++) begin
            wr_en = 1'b1; wr_data = word(k); wwait(1);
            if (k == 55) check("R6 at 55", wr_below_high, 1);
            if (k == 56) check("R6 at 56", wr_below_high, 0);
            if (k == 63) check("R5 at 63", wr_room, 1);
            if (k == 64) check("R5 at 64", wr_room, 0);
        end
        wr_en = 1'b0;
        rwait(4);
        check("R7 full count", rd_above_low, 1);
        rd_en = 1'b1;
        @(posedge rclk); rd_en <= 1'b0;
        @(posedge wclk); #2 check("R4 first edge", wr_room, 0);
        @(posedge wclk); #2 check("R4 second edge", wr_room, 1);
        check("R6 at 63", wr_below_high, 0);
        check("R3 first word", rd_data, word(1));
    endtask

    task automatic t_drain();
        rwait(1);
        for (int k = 2; k <= 64; k++) begin
            rd_en = 1'b1; rwait(1);
            check("R3 order", rd_data, word(k));
            if (64 - k == 9) check("R7 at 9", rd_above_low, 1);
            if (64 - k == 8) check("R7 at 8", rd_above_low, 0);
        end
        rd_en = 1'b0;
        check("R5 drained", rd_avail, 0);
        rwait(4);
        check("R1 overflow word absent", rd_avail, 0);
        wwait(4);
        check("R6 released", wr_below_high, 1);
        check("R4 room", wr_room, 1);
    endtask

    task automatic t_low_mark_rise();
        wwait(1);
        for (int k = 0; k < 8; k++) begin
            wr_en = 1'b1; wr_data = word(100 + k); wwait(1);
        end
        wr_en = 1'b0; rwait(4);
        check("R7 at 8 rising", rd_above_low, 0);
        check("R2 avail", rd_avail, 1);
        wr_en = 1'b1; wr_data = word(108); wwait(1); wr_en = 1'b0;
        rwait(4);
        check("R7 at 9 rising", rd_above_low, 1);
        for (int k = 0; k < 9; k++) begin
            rd_en = 1'b1; rwait(1);
        end
        rd_en = 1'b0;
        check("R3 last of batch", rd_data, word(108));
    endtask

    task automatic t_offset3();
        do_reset(6'd3);
        cfg_ofs = 6'd20;
        wwait(1);
        t_reset_state();
        for (int k = 1; k <= 61; k++) begin
            wr_en = 1'b1; wr_data = word(200 + k); wwait(1);
            if (k == 60) check("R8 high mark 60", wr_below_high, 1);
            if (k == 61) check("R8 high mark 61", wr_below_high, 0);
        end
        wr_en = 1'b0; rwait(4);
        for (int k = 1; k <= 58; k++) begin
            rd_en = 1'b1; rwait(1);
            if (61 - k == 4) check("R8 low mark 4", rd_above_low, 1);
            if (61 - k == 3) check("R8 low mark 3", rd_above_low, 0);
        end
        rd_en = 1'b0;
        check("R3 data X=3", rd_data, word(258));
    endtask

    initial begin
        do_reset(6'd8);
        wwait(1);
        t_reset_state();
        t_empty_latency();
        t_fill_and_release();
        t_drain();
        t_low_mark_rise();
        t_offset3();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule